// File: doc/BRIEF.md
# Element-Width Register Accessor

This block holds a bank of 64-bit registers and lets a single element of a chosen width be read or written in it. The bank is treated as one contiguous run of bytes. A base register, counted in whole 64-bit registers, marks where element 0 begins. Elements of 8, 16, 32 or 64 bits follow it back to back with no gaps. An element index large enough to pass the end of the base register moves on into the next registers.

Element 0 always sits in the least-significant bytes of the base register. Higher-numbered elements take higher byte lanes, and the lane placement does not depend on the processor's endianness. The register storage is inside the block. It has one synchronous write port with byte enables and one combinational read port. The read result is zero-extended to 64 bits.

An access whose element falls past the last implemented register raises a trap flag. A mode input picks either the full 128-register limit or a reduced 32-register limit for this check. A trapped access writes nothing and reads zero.

Top module: `ew_reg_accessor`

## Requirements
- R1: A synchronous active-high reset clears every byte of every register, so each read after reset returns zero.
- R2: The base register number is counted in 64-bit registers for every element width. Element 0 of any width starts at byte lane 0 of the base register.
- R3: The width code is 2'b00 for 64, 2'b01 for 32, 2'b10 for 16 and 2'b11 for 8 bits. The element starts at the linear byte offset base*8 + index*(width/8).
- R4: The read data holds the element in its low bits, and all bits above the element width are zero.
- R5: A write changes only the byte lanes of the addressed element. All other bytes of that register, and all other registers, keep their values. Bits of the write data above the element width are ignored.
- R6: The trap flag is high when the register that holds the element (byte offset divided by 8) is at or above the limit. The limit is 128 when `small_mode` is 0 and 32 when it is 1.
- R7: While the trap flag is high, a write stores nothing and the read data is zero.
- R8: Elements narrower than 64 bits continue contiguously into the following registers. Element 8/(width/8)*k lands at byte lane 0 of register base+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| small_mode | input | 1 | 1 selects the 32-register trap limit, 0 the 128-register limit |
| base_reg | input | 7 | Base register number in 64-bit units |
| elem_idx | input | 10 | Element index from the base register |
| elem_width | input | 2 | Element width code (see R3) |
| wr_data | input | 64 | Write element in its low bits |
| wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| rd_data | output | 64 | Zero-extended element read combinationally |
| trap | output | 1 | Access falls beyond the last implemented register |

## Verification
The hardest case to reach is a narrow element at a large index. Its byte offset carries it several registers past the base and onto a lane in the middle of a word, and it may cross the trap limit only in the reduced mode. The stimulus first fills the whole bank byte by byte. It then sweeps every index for each width, at several bases and in both modes, so that every lane position and every register crossing occurs, including the indices just before and just after the limit. Trapped writes aimed at the register just past the reduced limit are then read back in the full mode to show that they left no trace.

// File: rtl/ewacc_pkg.sv
package ewacc_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 8;
    localparam int unsigned WORD_W = BYTE_W * LANES;
    localparam int unsigned LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        EW_64 = 2'b00,
        EW_32 = 2'b01,
        EW_16 = 2'b10,
        EW_8  = 2'b11
    } ew_code_e;

    typedef struct packed {
        logic [LANE_W-1:0] lane;
        logic              trap;
    } ew_place_t;

    // log2 of element size in bytes
    function automatic logic [1:0] size_log2(ew_code_e c);
        return 2'd3 - 2'(c);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(ew_code_e c);
        case (c)
            EW_64:   return 8'hFF;
            EW_32:   return 8'h0F;
            EW_16:   return 8'h03;
            default: return 8'h01;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] bit_mask(ew_code_e c);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < int'(LANES); b++) begin
            m[b*BYTE_W +: BYTE_W] = {BYTE_W{lane_mask(c)[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/ew_addr_calc.sv
module ew_addr_calc
    import ewacc_pkg::*;
#(
    parameter int unsigned NREGS       = 128,
    parameter int unsigned NREGS_SMALL = 32,
    parameter int unsigned IDX_W       = 10,
    localparam int unsigned BASE_W     = $clog2(NREGS),
    localparam int unsigned OFF_W      = ((IDX_W > BASE_W) ? IDX_W : BASE_W) + 4,
    localparam int unsigned RSEL_W     = OFF_W - LANE_W
) (
    input  logic [BASE_W-1:0] base_reg,
    input  logic [IDX_W-1:0]  elem_idx,
    input  ew_code_e          elem_width,
    input  logic              small_mode,
    output logic [RSEL_W-1:0] reg_sel,
    output ew_place_t         place
);
    logic [OFF_W-1:0]  base_off;
    logic [OFF_W-1:0]  idx_off;
    logic [OFF_W-1:0]  byte_off;
    logic [RSEL_W-1:0] limit;

    always_comb begin
        base_off = '0;
        base_off[BASE_W+LANE_W-1:0] = {base_reg, {LANE_W{1'b0}}};
        idx_off  = OFF_W'(elem_idx) << size_log2(elem_width);
        byte_off = base_off + idx_off;
        reg_sel  = byte_off[OFF_W-1:LANE_W];
        limit    = small_mode ? RSEL_W'(NREGS_SMALL) : RSEL_W'(NREGS);
        place.lane = byte_off[LANE_W-1:0];
        place.trap = (reg_sel >= limit);
    end
endmodule

// File: rtl/ew_lane_align.sv
module ew_lane_align
    import ewacc_pkg::*;
(
    input  ew_code_e           elem_width,
    input  logic [LANE_W-1:0]  lane,
    input  logic [WORD_W-1:0]  wr_data,
    output logic [LANES-1:0]   lane_en,
    output logic [WORD_W-1:0]  wr_word
);
    always_comb begin
        lane_en = lane_mask(elem_width) << lane;
        wr_word = (wr_data & bit_mask(elem_width)) << {lane, 3'b000};
    end
endmodule

// File: rtl/ew_regbank.sv
module ew_regbank
    import ewacc_pkg::*;
#(
    parameter int unsigned NREGS  = 128,
    localparam int unsigned RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] addr,
    input  logic [LANES-1:0]  lane_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    for (genvar g = 0; g < int'(LANES); g++) begin : g_plane
        logic [BYTE_W-1:0] plane [NREGS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int r = 0; r < int'(NREGS); r++) begin
                    plane[r] <= '0;
                end
            end else if (we && lane_en[g]) begin
                plane[addr] <= wr_word[g*BYTE_W +: BYTE_W];
            end
        end

        assign rd_word[g*BYTE_W +: BYTE_W] = plane[addr];
    end
endmodule

// File: rtl/ew_reg_accessor.sv
module ew_reg_accessor
    import ewacc_pkg::*;
#(
    parameter int unsigned NREGS       = 128,
    parameter int unsigned NREGS_SMALL = 32,
    parameter int unsigned IDX_W       = 10,
    localparam int unsigned BASE_W     = $clog2(NREGS),
    localparam int unsigned OFF_W      = ((IDX_W > BASE_W) ? IDX_W : BASE_W) + 4,
    localparam int unsigned RSEL_W     = OFF_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              small_mode,
    input  logic [BASE_W-1:0] base_reg,
    input  logic [IDX_W-1:0]  elem_idx,
    input  logic [1:0]        elem_width,
    input  logic [63:0]       wr_data,
    input  logic              wr_en,
    output logic [63:0]       rd_data,
    output logic              trap
);
    ew_code_e          code;
    logic [RSEL_W-1:0] reg_sel;
    ew_place_t         place;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic              bank_we;

    assign code = ew_code_e'(elem_width);

    ew_addr_calc #(
        .NREGS       (NREGS),
        .NREGS_SMALL (NREGS_SMALL),
        .IDX_W       (IDX_W)
    ) u_addr (
        .base_reg   (base_reg),
        .elem_idx   (elem_idx),
        .elem_width (code),
        .small_mode (small_mode),
        .reg_sel    (reg_sel),
        .place      (place)
    );

    ew_lane_align u_align (
        .elem_width (code),
        .lane       (place.lane),
        .wr_data    (wr_data),
        .lane_en    (lane_en),
        .wr_word    (wr_word)
    );

    assign bank_we = wr_en && !place.trap;

    ew_regbank #(
        .NREGS (NREGS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (bank_we),
        .addr    (reg_sel[BASE_W-1:0]),
        .lane_en (lane_en),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    always_comb begin
        if (place.trap) begin
            rd_data = '0;
        end else begin
            rd_data = (rd_word >> {place.lane, 3'b000}) & bit_mask(code);
        end
        trap = place.trap;
    end
endmodule

// File: rtl/ew_reg_accessor_chk.sv
module ew_reg_accessor_chk #(
    parameter int unsigned NREGS_SMALL = 32,
    parameter int unsigned BASE_W      = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              small_mode,
    input logic [BASE_W-1:0] base_reg,
    input logic [1:0]        elem_width,
    input logic [63:0]       rd_data,
    input logic              trap,
    input logic              bank_we,
    input logic [7:0]        lane_en
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (rd_data == 64'd0));

    assert_byte_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (elem_width == 2'b11) |-> (rd_data[63:8] == 56'd0));

    assert_half_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
        (elem_width == 2'b10) |-> (rd_data[63:16] == 48'd0));

    assert_lane_count_R5: assert property (@(posedge clk) disable iff (rst)
        bank_we |-> ($countones(lane_en) == (8 >> elem_width)));

    assert_small_base_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (small_mode && (int'(base_reg) >= int'(NREGS_SMALL))) |-> trap);

    assert_trap_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        trap |-> !bank_we);

    assert_trap_zero_read_R7: assert property (@(posedge clk) disable iff (rst)
        trap |-> (rd_data == 64'd0));
endmodule

bind ew_reg_accessor ew_reg_accessor_chk #(
    .NREGS_SMALL (NREGS_SMALL),
    .BASE_W      (BASE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .small_mode (small_mode),
    .base_reg   (base_reg),
    .elem_width (elem_width),
    .rd_data    (rd_data),
    .trap       (trap),
    .bank_we    (bank_we),
    .lane_en    (lane_en)
);

// File: tb/test_ew_reg_accessor.sv
module test_ew_reg_accessor;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 128;
    localparam int NSMALL = 32;
    localparam int NBYTES = NREGS * 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        small_mode = 1'b0;
    logic [6:0]  base_reg = '0;
    logic [9:0]  elem_idx = '0;
    logic [1:0]  elem_width = '0;
    logic [63:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [63:0] rd_data;
    logic        trap;

    int checks = 0;
    int fails = 0;
    logic [7:0] bm [NBYTES];

    always #(CLK_PERIOD/2) clk = ~clk;

    ew_reg_accessor i_ew_reg_accessor (
        .clk        (clk),
        .rst        (rst),
        .small_mode (small_mode),
        .base_reg   (base_reg),
        .elem_idx   (elem_idx),
        .elem_width (elem_width),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .rd_data    (rd_data),
        .trap       (trap)
    );

    function automatic int nbytes(int c);
        return 8 >> c;
    endfunction

    // expected outcome from the requirements (R3, R6, R7)
    function automatic void expect_acc(input int m, input int b, input int i, input int c,
                                       output logic [63:0] d, output logic t);
        int off;
        int lim;
        off = b * 8 + i * nbytes(c);
        lim = m ? NSMALL : NREGS;
        d = '0;
        t = ((off / 8) >= lim);
        if (!t) begin
            for (int k = 0; k < nbytes(c); k++) begin
                d[k*8 +: 8] = bm[off + k];
            end
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_inputs(input int m, input int b, input int i, input int c);
        small_mode = m[0];
        base_reg   = 7'(b);
        elem_idx   = 10'(i);
        elem_width = 2'(c);
    endtask

    task automatic do_read(input string tag, input int m, input int b, input int i, input int c);
        logic [63:0] ed;
        logic et;
        @(negedge clk);
        set_inputs(m, b, i, c);
        #1;
        expect_acc(m, b, i, c, ed, et);
        check({tag, " data"}, rd_data, ed);
        check({tag, " trap"}, {63'd0, trap}, {63'd0, et});
    endtask

    task automatic do_write(input int m, input int b, input int i, input int c, input logic [63:0] d);
        logic [63:0] ed;
        logic et;
        int off;
        @(negedge clk);
        set_inputs(m, b, i, c);
        wr_data = d;
        wr_en = 1'b1;
        expect_acc(m, b, i, c, ed, et);
        off = b * 8 + i * nbytes(c);
        @(negedge clk);
        wr_en = 1'b0;
        if (!et) begin
            for (int k = 0; k < nbytes(c); k++) begin
                bm[off + k] = d[k*8 +: 8];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NBYTES; k++) bm[k] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every register reads zero after reset
        for (int r = 0; r < NREGS; r++) do_read("R1 reset", 0, r, 0, 0);

        // R5 R8: fill whole bank with byte elements, upper write bits are junk
        for (int i = 0; i < NBYTES; i++)
            do_write(0, 0, i, 3, {56'hA5C3_9E17_D4B2_60, 8'((i * 37 + 11) & 255)});

        // R2 R3 R4 R8: sweep every width over indices at several bases
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < (NBYTES / nbytes(c)) + 2 && i < 1024; i++)
                do_read("R3 R8 sweep base0", 0, 0, i, c);
            for (int i = 0; i < 80; i++)
                do_read("R2 R4 sweep base5", 0, 5, i, c);
            for (int i = 0; i < 40; i++)
                do_read("R2 sweep base17", 0, 17, i, c);
        end

        // R5: partial writes of wider elements, neighbours kept
        do_write(0, 3, 1, 2, 64'hFFFF_FFFF_FFFF_BEEF);
        do_write(0, 3, 1, 1, 64'h1111_1111_0BAD_F00D);
        do_write(0, 9, 5, 2, 64'h0000_0000_0000_1234);
        do_write(0, 10, 0, 0, 64'h0123_4567_89AB_CDEF);
        do_write(0, 10, 3, 3, 64'hFFFF_FFFF_FFFF_FF77);
        for (int r = 2; r < 13; r++) do_read("R5 neighbours", 0, r, 0, 0);
        for (int i = 0; i < 16; i++) do_read("R5 bytes", 0, 10, i, 3);

        // R6: reduced limit sweeps with each width
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < (8 / nbytes(c)) * 3; i++)
                do_read("R6 small limit", 1, 30, i, c);
        do_read("R6 small base over", 1, 40, 0, 0);
        do_read("R6 full top ok", 0, 127, 0, 0);
        do_read("R6 full top over", 0, 127, 1, 0);
        do_read("R6 full byte edge", 0, 127, 7, 3);
        do_read("R6 full byte over", 0, 127, 8, 3);

        // R7: trapped writes leave the bank unchanged
        do_write(1, 31, 8, 3, 64'h0000_0000_0000_00EE);
        do_write(1, 31, 1, 0, 64'hDEAD_DEAD_DEAD_DEAD);
        do_write(0, 127, 2, 1, 64'h0000_0000_CAFE_CAFE);
        do_read("R7 reg32 kept", 0, 32, 0, 0);
        do_read("R7 reg127 kept", 0, 127, 0, 0);
        do_read("R7 trap read zero", 1, 31, 9, 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule